// File: doc/BRIEF.md
# Timestamp and Periodic Interval Timer

This unit sits on a 16-bit register bus. It keeps a 32-bit free-running timestamp and a 32-bit reloading down counter. Software reads the timestamp as two 16-bit halves. A read of the low half takes a snapshot of the upper half at the same moment, so a low-then-high read sequence returns one consistent 32-bit value even when a carry into the upper half happens between the two reads.

The down counter is reloaded from a period register that software writes as two 16-bit halves. It counts at half the clock rate. A separate enable input starts it: on a 0-to-1 change of that input the counter loads the period and begins counting. Each time the counter runs out, a sticky event flag is set and the period is loaded again. Software clears the flag by writing a one to it. Typical use is to pace a periodic message, such as a ring beacon, from the event flag.

All read data is registered. It appears on `rdata_o` one clock after the read strobe and keeps that value until the next read.

Top module: `stamp_pit_timer`

## Requirements
- R1: The timestamp is 32 bits, resets to 0, increments by one on every clock edge after reset is released, and wraps modulo 2^32.
- R2: A read at byte address 0x64 returns timestamp bits 15:0 as sampled at the read edge. Data appears on `rdata_o` after that edge. In the same edge, timestamp bits 31:16 are copied into a holding register.
- R3: A read at 0x66 returns the holding register, not the live upper half.
- R4: Writes to 0x64 and 0x66 have no effect on the timestamp or on the holding register.
- R5: The period register is written and read as a low half at 0x68 and a high half at 0x6A. Both halves reset to zero.
- R6: On the clock edge where `pit_en_i` is first sampled high, the down counter loads the period P (P ≥ 1). The first expiry comes 2P edges after that load edge. Later expiries come every 2P edges.
- R7: The event flag (`event_o`, also readable as bit 0 at 0x6E) is set by an expiry and stays set. A write to 0x6E with data bit 0 set clears it. A write with bit 0 clear has no effect.
- R8: If an expiry and a clear land on the same edge, the flag stays set.
- R9: With `pit_en_i` low, the counter holds its value, no expiry occurs, and the event flag keeps its state. A later rise of the enable reloads the period and restarts the 2P timing.
- R10: A period write made while the timer is enabled takes effect only at the next reload. The interval already running finishes with the old period.
- R11: A period of zero expires on every count tick, which is every 2 edges. The first expiry comes 2 edges after the load. The counter never wraps to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the timestamp rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address of the register access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data, valid the cycle after `rd_i` |
| pit_en_i | input | 1 | Periodic timer enable; rising edge loads the period |
| event_o | output | 1 | Sticky expiry flag |

## Verification
On every cycle the assertions check the following:
- the timestamp step;
- the snapshot taken on a low-half read, and the high-half read returning that snapshot;
- the period load on an enable rise;
- the counter freezing while the timer is disabled;
- the reload from zero with no wrap;
- the event flag's set, clear and hold rules, including expiry winning over a simultaneous clear.

Only the bench scenarios can show the following:
- the exact 2P expiry spacing, measured in edges at the ports, for random periods;
- that a period written mid-interval delays its effect until the next reload;
- that a high-half read taken after a carry still returns the pre-carry upper half.

// File: rtl/stamp_pit_pkg.sv
package stamp_pit_pkg;
  localparam logic [7:0] A_TS_LO  = 8'h64;
  localparam logic [7:0] A_TS_HI  = 8'h66;
  localparam logic [7:0] A_PER_LO = 8'h68;
  localparam logic [7:0] A_PER_HI = 8'h6A;
  localparam logic [7:0] A_EVT    = 8'h6E;
endpackage

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int HALF_W = 16,
  localparam int TS_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snap_i,
  output logic [TS_W-1:0]   ts_o,
  output logic [HALF_W-1:0] hold_o
);
  logic [TS_W-1:0]   ts_q;
  logic [HALF_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q   <= '0;
      hold_q <= '0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (snap_i) hold_q <= ts_q[TS_W-1:HALF_W];
    end
  end

  assign ts_o   = ts_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/pit_core.sv
module pit_core #(
  parameter int HALF_W = 16,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             en_q, phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise, tick, last;

  assign rise = en_i & ~en_q;
  // half-rate tick, phase restarted at every load
  assign tick = en_i & ~rise & phase_q;
  // zero period counts as one tick so the counter never wraps
  assign last = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      en_q <= en_i;
      if (rise) begin
        cnt_q   <= period_i;
        phase_q <= 1'b0;
      end else if (en_i) begin
        phase_q <= ~phase_q;
        if (tick) cnt_q <= last ? period_i : cnt_q - 1'b1;
      end
    end
  end

  assign tick_o   = tick;
  assign expire_o = tick & last;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/stamp_regs.sv
module stamp_regs
  import stamp_pit_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 8,
  localparam int TS_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic [TS_W-1:0]   ts_i,
  input  logic [HALF_W-1:0] hold_i,
  input  logic              expire_i,
  output logic              snap_o,
  output logic [TS_W-1:0]   period_o,
  output logic              evt_o
);
  logic              evt_q, clr;
  logic [HALF_W-1:0] rd_mux, rdata_q;

  for (genvar h = 0; h < 2; h++) begin : g_per
    logic [HALF_W-1:0] per_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) per_q <= '0;
      else if (wr_i && addr_i == ADDR_W'(A_PER_LO + 8'(2 * h))) per_q <= wdata_i;
    end
    assign period_o[h*HALF_W +: HALF_W] = per_q;
  end

  assign snap_o = rd_i && (addr_i == ADDR_W'(A_TS_LO));
  assign clr    = wr_i && (addr_i == ADDR_W'(A_EVT)) && wdata_i[0];

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(A_TS_LO))       rd_mux = ts_i[HALF_W-1:0];
    else if (addr_i == ADDR_W'(A_TS_HI))  rd_mux = hold_i;
    else if (addr_i == ADDR_W'(A_PER_LO)) rd_mux = period_o[HALF_W-1:0];
    else if (addr_i == ADDR_W'(A_PER_HI)) rd_mux = period_o[TS_W-1:HALF_W];
    else if (addr_i == ADDR_W'(A_EVT))    rd_mux = HALF_W'(evt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      evt_q <= expire_i | (evt_q & ~clr);  // expiry wins over clear
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
  assign evt_o   = evt_q;
endmodule

// File: rtl/stamp_pit_timer.sv
module stamp_pit_timer #(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 8,
  localparam int TS_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic              pit_en_i,
  output logic              event_o
);
  logic              snap_w, expire_w, tick_w;
  logic [TS_W-1:0]   ts_w, period_w, cnt_w;
  logic [HALF_W-1:0] hold_w;

  stamp_counter #(.HALF_W(HALF_W)) i_stamp (
    .clk_i(clk_i), .rst_ni(rst_ni), .snap_i(snap_w),
    .ts_o(ts_w), .hold_o(hold_w)
  );

  pit_core #(.HALF_W(HALF_W)) i_pit (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pit_en_i), .period_i(period_w),
    .tick_o(tick_w), .expire_o(expire_w), .cnt_o(cnt_w)
  );

  stamp_regs #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ts_i(ts_w), .hold_i(hold_w),
    .expire_i(expire_w), .snap_o(snap_w), .period_o(period_w), .evt_o(event_o)
  );
endmodule

// File: rtl/stamp_pit_checker.sv
module stamp_pit_checker
  import stamp_pit_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ADDR_W = 8,
  localparam int TS_W = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [HALF_W-1:0] wdata_i,
  input logic [HALF_W-1:0] rdata_o,
  input logic              pit_en_i,
  input logic              event_o,
  input logic [TS_W-1:0]   ts_i,
  input logic [HALF_W-1:0] hold_i,
  input logic [TS_W-1:0]   cnt_i,
  input logic [TS_W-1:0]   period_i,
  input logic              tick_i,
  input logic              expire_i
);
  logic clr_req;
  assign clr_req = wr_i && addr_i == ADDR_W'(A_EVT) && wdata_i[0];

  p_ts_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ts_i == $past(ts_i) + 1'b1);

  p_snap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(A_TS_LO)) |=> hold_i == $past(ts_i[TS_W-1:HALF_W]));

  p_hi_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(A_TS_HI)) |=> rdata_o == $past(hold_i));

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pit_en_i) |=> cnt_i == $past(period_i));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !expire_i) |=> !event_o);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !clr_req) |=> event_o);

  p_expire_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> event_o);

  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pit_en_i |=> $stable(cnt_i));

  p_no_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == '0) |=> cnt_i == $past(period_i));
endmodule

bind stamp_pit_timer stamp_pit_checker #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pit_en_i(pit_en_i), .event_o(event_o),
  .ts_i(ts_w), .hold_i(hold_w), .cnt_i(cnt_w), .period_i(period_w),
  .tick_i(tick_w), .expire_i(expire_w)
);

// File: tb/test_stamp_pit_timer.sv
module test_stamp_pit_timer;
  localparam logic [7:0] TS_LO = 8'h64, TS_HI = 8'h66, PER_LO = 8'h68, PER_HI = 8'h6A, EVT = 8'h6E;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0, pit_en_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        event_o;

  int unsigned cyc;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else cyc <= cyc + 1;

  stamp_pit_timer i_stamp_pit_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pit_en_i(pit_en_i), .event_o(event_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [15:0] d, output int unsigned c);
    addr_i = a; rd_i = 1'b1; c = cyc;
    @(posedge clk_i);
    @(negedge clk_i);
    rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic set_period(input logic [31:0] p);
    bus_wr(PER_LO, p[15:0]);
    bus_wr(PER_HI, p[31:16]);
  endtask

  task automatic count_to_evt(output int n);
    n = 0;
    do begin
      edges(1);
      n++;
    end while (!event_o && n < 5000);
  endtask

  function automatic int first_gap(input int p);
    return (p == 0) ? 3 : 2 * p + 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int unsigned c, c2;
    int n, p;
    logic [31:0] pv;
    void'($urandom(32'd1234));

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    check("R7 event after reset", event_o, 0);
    check("R2 rdata after reset", rdata_o, 0);
    bus_rd(PER_LO, d, c); check("R5 period lo reset", d, 0);
    bus_rd(PER_HI, d, c); check("R5 period hi reset", d, 0);

    // R1/R2: timestamp low half tracks the edge count
    for (int i = 0; i < 5; i++) begin
      edges($urandom_range(1, 40));
      bus_rd(TS_LO, d, c);
      check("R1 R2 ts lo", d, c[15:0]);
    end

    // R4: writes to timestamp halves ignored
    bus_wr(TS_LO, 16'hABCD);
    bus_wr(TS_HI, 16'h1234);
    bus_rd(TS_LO, d, c); check("R4 ts lo after write", d, c[15:0]);
    bus_rd(TS_HI, d, c2); check("R4 ts hi after write", d, c[31:16]);

    // R5: period readback
    for (int i = 0; i < 4; i++) begin
      pv = $urandom;
      set_period(pv);
      bus_rd(PER_LO, d, c); check("R5 period lo", d, pv[15:0]);
      bus_rd(PER_HI, d, c); check("R5 period hi", d, pv[31:16]);
    end

    // R6/R7: random periods
    for (int i = 0; i < 6; i++) begin
      p = $urandom_range(2, 200);
      set_period(32'(p));
      pit_en_i = 1'b1;
      count_to_evt(n); check("R6 first interval", 32'(n), 32'(first_gap(p)));
      bus_wr(EVT, 16'h0001); check("R7 cleared", event_o, 0);
      count_to_evt(n); check("R6 repeat interval", 32'(n + 1), 32'(2 * p));
      pit_en_i = 1'b0;
      bus_wr(EVT, 16'h0000); check("R7 write zero keeps flag", event_o, 1);
      bus_rd(EVT, d, c); check("R7 flag readback", d, 1);
      bus_wr(EVT, 16'h0001);
    end

    // R9: disable holds, keeps flag, re-enable restarts
    set_period(32'd50);
    pit_en_i = 1'b1;
    count_to_evt(n); check("R9 initial interval", 32'(n), 101);
    edges(30);
    pit_en_i = 1'b0;
    edges(300); check("R9 flag kept while off", event_o, 1);
    bus_wr(EVT, 16'h0001);
    edges(200); check("R9 no expiry while off", event_o, 0);
    pit_en_i = 1'b1;
    count_to_evt(n); check("R9 reload on re-enable", 32'(n), 101);
    pit_en_i = 1'b0;
    bus_wr(EVT, 16'h0001);

    // R8: clear coinciding with expiry (period 1, expiry every 2 edges)
    set_period(32'd1);
    pit_en_i = 1'b1;
    count_to_evt(n); check("R6 period one", 32'(n), 3);
    edges(1);
    bus_wr(EVT, 16'h0001); check("R8 expiry beats clear", event_o, 1);
    bus_wr(EVT, 16'h0001); check("R8 clear off-expiry", event_o, 0);
    edges(1); check("R8 next expiry", event_o, 1);
    pit_en_i = 1'b0;
    bus_wr(EVT, 16'h0001);

    // R11: zero period
    set_period(32'd0);
    pit_en_i = 1'b1;
    count_to_evt(n); check("R11 first expiry", 32'(n), 3);
    bus_wr(EVT, 16'h0001); check("R11 cleared", event_o, 0);
    count_to_evt(n); check("R11 every tick", 32'(n), 1);
    pit_en_i = 1'b0;
    bus_wr(EVT, 16'h0001);

    // R10: mid-interval period write
    set_period(32'd40);
    pit_en_i = 1'b1;
    count_to_evt(n); check("R10 old period", 32'(n), 81);
    bus_wr(PER_LO, 16'd10);
    bus_wr(EVT, 16'h0001);
    count_to_evt(n); check("R10 running interval keeps old period", 32'(n + 2), 80);
    bus_wr(EVT, 16'h0001);
    count_to_evt(n); check("R10 new period after reload", 32'(n + 1), 20);
    pit_en_i = 1'b0;
    bus_wr(EVT, 16'h0001);

    // R3: snapshot across a carry into the upper half
    while (cyc < 65530) @(negedge clk_i);
    bus_rd(TS_LO, d, c); check("R2 ts lo near carry", d, c[15:0]);
    edges(40);
    bus_rd(TS_HI, d, c2); check("R3 hi returns snapshot", d, c[31:16]);
    bus_rd(TS_LO, d, c); check("R1 ts lo after carry", d, c[15:0]);
    bus_rd(TS_HI, d, c2); check("R3 hi after carry", d, c[31:16]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule